// File: doc/BRIEF.md
# Slot-Scheduled Video DMA Source Engine

This block is the source side of a video DMA. It owns the source pointer, the transfer length, the destination address and its step, and a small command field. Once a run is started it produces write-queue entries for a video memory write queue, at most one entry per access slot. The slot timing comes from outside: each slot brings a slot index, the active line width, a "queue saw an unused slot" flag and a "queue is full" flag.

There are three ways to produce data. An external transfer reads a combinational external-memory stub at the 24-bit source pointer. A fill repeats the last value the host wrote to the data port, and that host write is also what starts the fill. A copy reads back the video memory named by the destination code, and it may only do so in a slot where the queue left the memory idle. Every entry leaves with a due stamp three slots after the slot that produced it. When the length runs out the run ends and the start bits of the command are cleared.

The controller is a four-state machine. The states are `ST_IDLE`, `ST_XFER` (external transfer), `ST_FILL` and `ST_COPY`. A configuration load in `ST_IDLE` with command bit 5 set moves to `ST_XFER` or `ST_COPY`, depending on the mode bits. A host data write in `ST_IDLE` or `ST_FILL`, with bit 5 set and fill mode selected, moves to (or restarts) `ST_FILL`. In each running state, the step that brings the length to zero returns the machine to `ST_IDLE`.

Top module: `vdma_src_engine`

## Requirements
- R1: The mode is decoded from `cfg_src[23:22]`: 00 or 01 selects an external transfer, 10 selects a fill, and 11 selects a copy. A `cfg_load` is taken only while `dma_run` is low. It starts a run at once if `cfg_cmd[5]` is set and the mode is not fill. A `cfg_load` while running has no effect.
- R2: No step is taken in a slot with `q_full` high. No step is taken in a refresh slot. With `wide_mode` high the refresh slots are 37, 69, 102, 133, 165, 197 and every index from 210 to 255. With `wide_mode` low they are 24, 56, 88, 120 and 152.
- R3: An external transfer steps only if `slot_idx` is 0 or slot `slot_idx-1` is not a refresh slot. In that slot `ext_req` is high and `ext_addr` shows the source pointer.
- R4: A copy steps only in a slot with `q_unused` high, and it raises `unused_take` in that slot. The destination code is `dma_cmd[3:0]`: 1 is pattern RAM, 3 is colour RAM, 5 is scroll RAM. For code 1 it reads pattern RAM (`cp_ram`=0) at {middle, low} source bytes and keeps only the low 8 bits. For code 3 it reads colour RAM (`cp_ram`=1) at the low source byte mod 64. For code 5 it reads scroll RAM (`cp_ram`=2) at the low source byte mod 64. Any other code reads 0.
- R5: A scroll RAM copy whose index (low source byte mod 64) is 40 or more returns 0.
- R6: A fill uses the last accepted host data value. For code 1 it sends the upper byte, zero-extended, with `q_partial` high. For other codes it sends the full value with `q_partial` low.
- R7: A step raises `q_push` for exactly the cycle after its slot. The entry carries `q_addr` equal to the destination before the step, `q_code` equal to `dma_cmd[3:0]`, and `q_due` equal to the number of slot ticks before that slot plus 3 (mod 2^16).
- R8: After each step the low source byte increments and carries only into the middle byte; the high byte never changes. The destination address advances by `cfg_inc`.
- R9: Each step decrements the length. The step that brings it to zero drops `dma_run` and clears `dma_cmd[5:4]`. A length of 0 runs 65536 steps.
- R10: A host data write while an external transfer or a copy is running is rejected: `host_rej` is high for the next cycle and the value is not kept.
- R11: A host data write with `dma_cmd[5]` set and fill mode selected starts a fill from idle, or restarts a running fill with the new value. A fill configuration alone does not start a run.
- R12: `q_push` is never high unless a slot tick was present in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load source, length, destination, step and command |
| cfg_src | input | 24 | Source pointer; bits 23:22 select the mode |
| cfg_len | input | 16 | Transfer length in words (0 means 65536) |
| cfg_dest | input | 16 | Destination address |
| cfg_inc | input | 8 | Destination step per entry |
| cfg_cmd | input | 6 | Command: bit 5 start, bits 3:0 destination code |
| host_wr | input | 1 | Host data-port write strobe |
| host_data | input | 16 | Host data-port value |
| host_rej | output | 1 | Host write was refused (one cycle, registered) |
| slot_tick | input | 1 | An access slot occurs this cycle |
| slot_idx | input | 8 | Index of the current slot within the line |
| wide_mode | input | 1 | Wide line timing (selects the refresh set) |
| q_unused | input | 1 | Queue left this slot's memory access unused |
| q_full | input | 1 | Write queue cannot accept an entry |
| unused_take | output | 1 | Copy consumed the unused slot (combinational) |
| ext_req | output | 1 | External read this cycle (combinational) |
| ext_addr | output | 24 | External read address |
| ext_rdata | input | 16 | External read data, same cycle |
| cp_ram | output | 2 | Copy read RAM select: 0 pattern, 1 colour, 2 scroll, 3 none |
| cp_addr | output | 16 | Copy read address |
| cp_rdata | input | 16 | Copy read data, same cycle |
| q_push | output | 1 | Queue entry valid (one cycle) |
| q_addr | output | 16 | Entry destination address |
| q_data | output | 16 | Entry data |
| q_code | output | 4 | Entry destination code |
| q_partial | output | 1 | Entry performs only the low-address byte write |
| q_due | output | 16 | Slot stamp when the entry becomes eligible |
| dma_run | output | 1 | Run flag |
| dma_cmd | output | 6 | Current command field |

## Verification
The assertions assume that `slot_idx` and `wide_mode` are stable and meaningful in any cycle with `slot_tick` high. They also assume `q_unused` is a truthful queue report. The bench drives configuration loads, host writes and slot ticks in separate cycles, so no host write ever lands on the same edge as a step. It also lets the fill restart only when the length left is more than one. Slot indices in the random mix lean towards refresh slots and the slots right after them, so the gating rules in R2 and R3 are exercised far more often than an even spread would allow.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int SRC_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FILL = 2'd2,
        ST_COPY = 2'd3
    } vdma_state_e;

    typedef enum logic [1:0] {
        RAM_PAT  = 2'd0,
        RAM_COL  = 2'd1,
        RAM_SCR  = 2'd2,
        RAM_NONE = 2'd3
    } vdma_ram_e;

    localparam logic [3:0] CODE_PAT = 4'h1;
    localparam logic [3:0] CODE_COL = 4'h3;
    localparam logic [3:0] CODE_SCR = 4'h5;

    localparam logic [1:0] MODE_FILL = 2'b10;

    // Running state chosen by the two mode bits of the source high byte.
    function automatic vdma_state_e run_state(input logic [1:0] mode_bits);
        if (mode_bits == 2'b11)      return ST_COPY;
        else if (mode_bits == 2'b10) return ST_FILL;
        else                         return ST_XFER;
    endfunction

endpackage

// File: rtl/vdma_refresh_map.sv
module vdma_refresh_map #(
    parameter int SLOT_W = 8
) (
    input  logic [SLOT_W-1:0] idx,
    input  logic              wide,
    output logic              is_ref
);

    always_comb begin
        if (wide) begin
            is_ref = (idx == SLOT_W'(37))  || (idx == SLOT_W'(69))  ||
                     (idx == SLOT_W'(102)) || (idx == SLOT_W'(133)) ||
                     (idx == SLOT_W'(165)) || (idx == SLOT_W'(197)) ||
                     (idx >= SLOT_W'(210));
        end else begin
            is_ref = (idx == SLOT_W'(24))  || (idx == SLOT_W'(56))  ||
                     (idx == SLOT_W'(88))  || (idx == SLOT_W'(120)) ||
                     (idx == SLOT_W'(152));
        end
    end

endmodule

// File: rtl/vdma_src_regs.sv
module vdma_src_regs
    import vdma_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int DEST_W = 16,
    parameter int INC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SRC_W-1:0]  ld_src,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic [DEST_W-1:0] ld_dest,
    input  logic [INC_W-1:0]  ld_inc,
    input  logic              step,
    output logic [SRC_W-1:0]  src,
    output logic [DEST_W-1:0] dest,
    output logic              last_step
);

    logic [LEN_W-1:0] len_q;
    logic [INC_W-1:0] inc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src   <= '0;
            dest  <= '0;
            len_q <= '0;
            inc_q <= '0;
        end else if (load) begin
            src   <= ld_src;
            dest  <= ld_dest;
            len_q <= ld_len;
            inc_q <= ld_inc;
        end else if (step) begin
            // low byte steps; carry reaches the middle byte and stops there
            src[7:0] <= src[7:0] + 8'd1;
            if (src[7:0] == 8'hFF)
                src[15:8] <= src[15:8] + 8'd1;
            dest  <= dest + DEST_W'(inc_q);
            len_q <= len_q - LEN_W'(1);
        end
    end

    // decrement happens before the zero test, so a loaded zero wraps first
    assign last_step = (len_q == LEN_W'(1));

endmodule

// File: rtl/vdma_src_engine.sv
module vdma_src_engine
    import vdma_pkg::*;
#(
    parameter int SLOT_W       = 8,
    parameter int LEN_W        = 16,
    parameter int DEST_W       = 16,
    parameter int INC_W        = 8,
    parameter int DATA_W       = 16,
    parameter int DUE_W        = 16,
    parameter int LATENCY      = 3,
    parameter int IDX_W        = 6,
    parameter int SCROLL_DEPTH = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [23:0]       cfg_src,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DEST_W-1:0] cfg_dest,
    input  logic [INC_W-1:0]  cfg_inc,
    input  logic [5:0]        cfg_cmd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    output logic              host_rej,
    input  logic              slot_tick,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              wide_mode,
    input  logic              q_unused,
    input  logic              q_full,
    output logic              unused_take,
    output logic              ext_req,
    output logic [23:0]       ext_addr,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [1:0]        cp_ram,
    output logic [DEST_W-1:0] cp_addr,
    input  logic [DATA_W-1:0] cp_rdata,
    output logic              q_push,
    output logic [DEST_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_data,
    output logic [3:0]        q_code,
    output logic              q_partial,
    output logic [DUE_W-1:0]  q_due,
    output logic              dma_run,
    output logic [5:0]        dma_cmd
);

    localparam int NPROBE = 2;

    vdma_state_e       state_q, state_d;
    logic [SRC_W-1:0]  src;
    logic [DEST_W-1:0] dest;
    logic              last_step;
    logic [5:0]        cmd_q;
    logic [DATA_W-1:0] last_q;
    logic [DUE_W-1:0]  tick_q;
    logic [3:0]        code;
    logic [1:0]        mode;
    logic              running, cfg_ok, start_run, fill_arm, host_ok;
    logic              slot_open, step_go, finish, idx_in_range;
    logic [DATA_W-1:0] copy_val, src_val;

    // refresh lookup for this slot (probe 0) and the slot before it (probe 1)
    logic [SLOT_W-1:0] probe [NPROBE];
    logic [NPROBE-1:0] ref_vec;

    assign probe[0] = slot_idx;
    assign probe[1] = slot_idx - SLOT_W'(1);

    for (genvar g = 0; g < NPROBE; g++) begin : g_ref
        vdma_refresh_map #(.SLOT_W(SLOT_W)) u_map (
            .idx    (probe[g]),
            .wide   (wide_mode),
            .is_ref (ref_vec[g])
        );
    end

    vdma_src_regs #(.LEN_W(LEN_W), .DEST_W(DEST_W), .INC_W(INC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_ok),
        .ld_src    (cfg_src),
        .ld_len    (cfg_len),
        .ld_dest   (cfg_dest),
        .ld_inc    (cfg_inc),
        .step      (step_go),
        .src       (src),
        .dest      (dest),
        .last_step (last_step)
    );

    assign code      = cmd_q[3:0];
    assign mode      = src[SRC_W-1:SRC_W-2];
    assign running   = (state_q != ST_IDLE);
    assign cfg_ok    = cfg_load && !running;
    assign start_run = cfg_ok && cfg_cmd[5] && (cfg_src[23:22] != MODE_FILL);
    assign fill_arm  = host_wr && cmd_q[5] && (mode == MODE_FILL) &&
                       (state_q == ST_IDLE || state_q == ST_FILL);
    assign host_ok   = host_wr && (!running || state_q == ST_FILL);
    assign slot_open = slot_tick && running && !ref_vec[0] && !q_full;

    always_comb begin
        unique case (state_q)
            ST_XFER: step_go = slot_open && ((slot_idx == '0) || !ref_vec[1]);
            ST_FILL: step_go = slot_open;
            ST_COPY: step_go = slot_open && q_unused;
            ST_IDLE: step_go = 1'b0;
            default: step_go = 1'b0;
        endcase
    end

    assign finish      = step_go && last_step;
    assign ext_req     = step_go && (state_q == ST_XFER);
    assign ext_addr    = src;
    assign unused_take = step_go && (state_q == ST_COPY);

    // copy read port: RAM and index picked by the destination code
    always_comb begin
        cp_ram       = RAM_NONE;
        cp_addr      = '0;
        idx_in_range = 1'b0;
        if (code == CODE_PAT) begin
            cp_ram       = RAM_PAT;
            cp_addr      = DEST_W'(src[15:0]);
            idx_in_range = 1'b1;
        end else if (code == CODE_COL) begin
            cp_ram       = RAM_COL;
            cp_addr      = DEST_W'(src[IDX_W-1:0]);
            idx_in_range = 1'b1;
        end else if (code == CODE_SCR) begin
            cp_ram       = RAM_SCR;
            cp_addr      = DEST_W'(src[IDX_W-1:0]);
            idx_in_range = (src[IDX_W-1:0] < IDX_W'(SCROLL_DEPTH));
        end
    end

    always_comb begin
        if (!idx_in_range)          copy_val = '0;
        else if (code == CODE_PAT)  copy_val = {{(DATA_W-8){1'b0}}, cp_rdata[7:0]};
        else                        copy_val = cp_rdata;
    end

    always_comb begin
        unique case (state_q)
            ST_XFER: src_val = ext_rdata;
            ST_COPY: src_val = copy_val;
            ST_FILL: src_val = (code == CODE_PAT) ?
                               {{(DATA_W-8){1'b0}}, last_q[DATA_W-1:DATA_W-8]} : last_q;
            ST_IDLE: src_val = '0;
            default: src_val = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_run)     state_d = run_state(cfg_src[23:22]);
                else if (fill_arm) state_d = ST_FILL;
            end
            ST_XFER, ST_COPY: begin
                if (finish) state_d = ST_IDLE;
            end
            ST_FILL: begin
                if (fill_arm)    state_d = ST_FILL;
                else if (finish) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_push    <= 1'b0;
            q_addr    <= '0;
            q_data    <= '0;
            q_code    <= '0;
            q_partial <= 1'b0;
            q_due     <= '0;
            host_rej  <= 1'b0;
            cmd_q     <= '0;
            last_q    <= '0;
            tick_q    <= '0;
        end else begin
            q_push   <= step_go;
            host_rej <= host_wr && !host_ok;
            if (slot_tick)
                tick_q <= tick_q + DUE_W'(1);
            if (host_ok)
                last_q <= host_data;
            if (step_go) begin
                q_addr    <= dest;
                q_data    <= src_val;
                q_code    <= code;
                q_partial <= (state_q == ST_FILL) && (code == CODE_PAT);
                q_due     <= tick_q + DUE_W'(LATENCY);
            end
            if (cfg_ok)
                cmd_q <= cfg_cmd;
            else if (running && state_d == ST_IDLE)
                cmd_q <= {2'b00, cmd_q[3:0]};
        end
    end

    assign dma_run = running;
    assign dma_cmd = cmd_q;

endmodule

// File: rtl/vdma_src_engine_chk.sv
module vdma_src_engine_chk #(
    parameter int SLOT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_tick,
    input logic [SLOT_W-1:0] slot_idx,
    input logic              wide_mode,
    input logic              q_full,
    input logic              q_unused,
    input logic              unused_take,
    input logic              ext_req,
    input logic              q_push,
    input logic              host_wr,
    input logic              host_rej,
    input logic              dma_run,
    input logic [5:0]        dma_cmd
);

    assert_push_after_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> $past(slot_tick));

    assert_no_push_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> !$past(q_full));

    assert_no_push_in_refresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> !($past(wide_mode) && $past(slot_idx) == SLOT_W'(37)));

    assert_ext_skips_after_refresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> !(wide_mode && slot_idx == SLOT_W'(38)));

    assert_take_needs_unused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unused_take |-> q_unused);

    assert_push_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> $past(dma_run));

    assert_end_clears_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_run) |-> (dma_cmd[5:4] == 2'b00));

    assert_reject_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rej |-> ($past(host_wr) && $past(dma_run)));

endmodule

bind vdma_src_engine vdma_src_engine_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_tick   (slot_tick),
    .slot_idx    (slot_idx),
    .wide_mode   (wide_mode),
    .q_full      (q_full),
    .q_unused    (q_unused),
    .unused_take (unused_take),
    .ext_req     (ext_req),
    .q_push      (q_push),
    .host_wr     (host_wr),
    .host_rej    (host_rej),
    .dma_run     (dma_run),
    .dma_cmd     (dma_cmd)
);

// File: tb/vdma_src_engine_tb.sv
`timescale 1ns/1ps
module vdma_src_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_load;
    logic [23:0] cfg_src;
    logic [15:0] cfg_len, cfg_dest;
    logic [7:0]  cfg_inc;
    logic [5:0]  cfg_cmd;
    logic        host_wr;
    logic [15:0] host_data;
    logic        host_rej;
    logic        slot_tick;
    logic [7:0]  slot_idx;
    logic        wide_mode, q_unused, q_full;
    logic        unused_take, ext_req;
    logic [23:0] ext_addr;
    logic [15:0] ext_rdata;
    logic [1:0]  cp_ram;
    logic [15:0] cp_addr, cp_rdata;
    logic        q_push;
    logic [15:0] q_addr, q_data;
    logic [3:0]  q_code;
    logic        q_partial;
    logic [15:0] q_due;
    logic        dma_run;
    logic [5:0]  dma_cmd;

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // memory stubs
    function automatic logic [15:0] ext_model(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], 8'h5A} ^ 16'h3C00;
    endfunction

    function automatic logic [15:0] cp_model(input logic [1:0] r, input logic [15:0] a);
        return (a * 16'd3) ^ {r, 14'h0A55};
    endfunction

    assign ext_rdata = ext_model(ext_addr);
    assign cp_rdata  = cp_model(cp_ram, cp_addr);

    vdma_src_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_len(cfg_len),
        .cfg_dest(cfg_dest), .cfg_inc(cfg_inc), .cfg_cmd(cfg_cmd),
        .host_wr(host_wr), .host_data(host_data), .host_rej(host_rej),
        .slot_tick(slot_tick), .slot_idx(slot_idx), .wide_mode(wide_mode),
        .q_unused(q_unused), .q_full(q_full), .unused_take(unused_take),
        .ext_req(ext_req), .ext_addr(ext_addr), .ext_rdata(ext_rdata),
        .cp_ram(cp_ram), .cp_addr(cp_addr), .cp_rdata(cp_rdata),
        .q_push(q_push), .q_addr(q_addr), .q_data(q_data), .q_code(q_code),
        .q_partial(q_partial), .q_due(q_due), .dma_run(dma_run), .dma_cmd(dma_cmd)
    );

    // bench model state
    logic [23:0] m_src;
    logic [15:0] m_dest, m_last, m_ticks;
    logic [7:0]  m_inc;
    logic [5:0]  m_cmd;
    int          m_len;
    bit          m_run;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_ref(input int idx, input bit wide);
        if (wide)
            return idx == 37 || idx == 69 || idx == 102 || idx == 133 ||
                   idx == 165 || idx == 197 || idx >= 210;
        return idx == 24 || idx == 56 || idx == 88 || idx == 120 || idx == 152;
    endfunction

    // 0 external, 1 fill, 2 copy
    function automatic int mode_of(input logic [23:0] s);
        if (s[23:22] == 2'b10) return 1;
        if (s[23:22] == 2'b11) return 2;
        return 0;
    endfunction

    function automatic logic [15:0] exp_data(input int md);
        logic [15:0] t;
        if (md == 0) return ext_model(m_src);
        if (md == 1) return (m_cmd[3:0] == 4'h1) ? {8'h00, m_last[15:8]} : m_last;
        case (m_cmd[3:0])
            4'h1: begin t = cp_model(2'd0, m_src[15:0]); return {8'h00, t[7:0]}; end
            4'h3: return cp_model(2'd1, {10'd0, m_src[5:0]});
            4'h5: return (m_src[5:0] < 6'd40) ? cp_model(2'd2, {10'd0, m_src[5:0]}) : 16'h0;
            default: return 16'h0;
        endcase
    endfunction

    task automatic idle_inputs();
        cfg_load = 0; host_wr = 0; slot_tick = 0;
    endtask

    task automatic do_cfg(input logic [23:0] s, input logic [15:0] l, input logic [15:0] d,
                          input logic [7:0] inc, input logic [5:0] c);
        cfg_load = 1; cfg_src = s; cfg_len = l; cfg_dest = d; cfg_inc = inc; cfg_cmd = c;
        @(posedge clk); @(negedge clk);
        cfg_load = 0;
        if (!m_run) begin
            m_src = s; m_len = (l == 0) ? 65536 : int'(l); m_dest = d; m_inc = inc; m_cmd = c;
            if (c[5] && mode_of(s) != 1) m_run = 1;
        end
        chk("R1 run flag after load", dma_run, m_run);
        chk("R1 command after load", dma_cmd, m_cmd);
    endtask

    task automatic do_host(input logic [15:0] v);
        bit rej;
        host_wr = 1; host_data = v;
        @(posedge clk); @(negedge clk);
        host_wr = 0;
        rej = m_run && mode_of(m_src) != 1;
        chk("R10 host reject flag", host_rej, rej);
        if (!rej) begin
            m_last = v;
            if (m_cmd[5] && mode_of(m_src) == 1) m_run = 1;
        end
        chk("R11 run flag after host write", dma_run, m_run);
    endtask

    task automatic run_slot(input int idx, input bit wide, input bit unused, input bit full);
        bit rn, rp, go;
        int md;
        logic [15:0] ed;
        rn = exp_ref(idx, wide);
        rp = exp_ref((idx + 255) % 256, wide);
        md = mode_of(m_src);
        go = m_run && !rn && !full &&
             ((md == 0) ? (idx == 0 || !rp) : (md == 1) ? 1'b1 : unused);
        ed = exp_data(md);
        slot_tick = 1; slot_idx = 8'(idx); wide_mode = wide; q_unused = unused; q_full = full;
        #1;
        chk("R3 external request", ext_req, go && md == 0);
        if (go && md == 0) chk("R3 external address", ext_addr, m_src);
        chk("R4 unused slot taken", unused_take, go && md == 2);
        @(posedge clk); @(negedge clk);
        slot_tick = 0;
        chk("R2 R3 R4 R12 step gating", q_push, go);
        if (go) begin
            chk("R4 R5 R6 entry data", q_data, ed);
            chk("R7 entry address", q_addr, m_dest);
            chk("R7 entry code", q_code, m_cmd[3:0]);
            chk("R6 entry partial", q_partial, md == 1 && m_cmd[3:0] == 4'h1);
            chk("R7 entry due stamp", q_due, 16'(m_ticks + 16'd3));
            m_src[7:0] = m_src[7:0] + 8'd1;
            if (m_src[7:0] == 8'h00) m_src[15:8] = m_src[15:8] + 8'd1;
            m_dest = m_dest + {8'h00, m_inc};
            m_len--;
            if (m_len == 0) begin
                m_run = 0;
                m_cmd = {2'b00, m_cmd[3:0]};
            end
        end
        m_ticks = m_ticks + 16'd1;
        chk("R9 run flag", dma_run, m_run);
        chk("R9 command field", dma_cmd, m_cmd);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        rst_n = 0; idle_inputs();
        cfg_src = 0; cfg_len = 0; cfg_dest = 0; cfg_inc = 0; cfg_cmd = 0;
        host_data = 0; slot_idx = 0; wide_mode = 1; q_unused = 0; q_full = 0;
        m_src = 0; m_dest = 0; m_last = 0; m_ticks = 0; m_inc = 0; m_cmd = 0; m_len = 0; m_run = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", dma_run, 0);
        chk("R7 no push after reset", q_push, 0);
        chk("R10 no reject after reset", host_rej, 0);
        chk("R9 command clear after reset", dma_cmd, 0);

        // external transfer with carry from low into middle byte
        do_cfg(24'h40_12FE, 16'd3, 16'h0100, 8'd2, 6'h21);
        run_slot(5, 1, 0, 0);
        chk("R7 first due stamp", q_due, 16'd3);
        run_slot(37, 1, 0, 0);
        chk("R2 refresh slot blocks", q_push, 0);
        run_slot(38, 1, 0, 0);
        chk("R3 slot after refresh blocks", q_push, 0);
        run_slot(25, 0, 0, 0);
        chk("R3 narrow slot after refresh blocks", q_push, 0);
        run_slot(0, 1, 0, 0);
        chk("R3 slot zero allowed", q_push, 1);
        run_slot(6, 1, 0, 0);
        chk("R8 carry into middle byte", q_data, ext_model(24'h40_1300));
        chk("R8 destination step", q_addr, 16'h0104);
        chk("R9 run ends", dma_run, 0);
        chk("R9 start bits cleared", dma_cmd, 6'h01);

        // no carry into high byte; full queue; load ignored while running
        do_cfg(24'h3F_FFFF, 16'd2, 16'h0000, 8'd1, 6'h21);
        run_slot(7, 1, 0, 1);
        chk("R2 full queue blocks", q_push, 0);
        run_slot(7, 1, 0, 0);
        do_cfg(24'h01_0000, 16'd9, 16'h0FFF, 8'd9, 6'h23);
        do_host(16'h7777);
        chk("R10 rejected during transfer", host_rej, 1);
        run_slot(8, 1, 0, 0);
        chk("R8 high byte untouched", q_data, ext_model(24'h3F_0000));

        // copies
        do_cfg(24'hC0_0045, 16'd2, 16'h0040, 8'd1, 6'h35);
        run_slot(10, 1, 0, 0);
        chk("R4 copy waits for unused slot", q_push, 0);
        run_slot(10, 1, 1, 0);
        chk("R4 scroll index mod 64", q_data, cp_model(2'd2, 16'h0005));
        run_slot(11, 1, 1, 0);
        do_cfg(24'hC0_0027, 16'd2, 16'h0000, 8'd1, 6'h35);
        run_slot(12, 1, 1, 0);
        run_slot(13, 1, 1, 0);
        chk("R5 scroll index 40 reads zero", q_data, 16'h0);
        do_cfg(24'hC0_1234, 16'd1, 16'h0000, 8'd2, 6'h31);
        run_slot(14, 1, 1, 0);
        chk("R4 pattern copy low byte", q_data, {8'h00, cp_model(2'd0, 16'h1234) & 16'h00FF});

        // fills
        do_cfg(24'h80_0000, 16'd3, 16'h0200, 8'd1, 6'h21);
        chk("R11 fill waits for host write", dma_run, 0);
        do_host(16'hBEEF);
        chk("R11 host write starts fill", dma_run, 1);
        run_slot(38, 1, 0, 0);
        chk("R6 pattern fill upper byte", q_data, 16'h00BE);
        chk("R6 pattern fill partial", q_partial, 1);
        do_host(16'h1357);
        chk("R11 fill restart accepted", host_rej, 0);
        run_slot(39, 1, 0, 0);
        chk("R11 restarted fill value", q_data, 16'h0013);
        run_slot(40, 1, 0, 0);
        do_cfg(24'h80_0000, 16'd1, 16'h0300, 8'd1, 6'h23);
        do_host(16'hCAFE);
        run_slot(3, 0, 0, 0);
        chk("R6 colour fill full value", q_data, 16'hCAFE);
        chk("R6 colour fill not partial", q_partial, 0);

        // zero length runs 65536 steps
        do_cfg(24'h80_0000, 16'd0, 16'h0000, 8'd2, 6'h23);
        do_host(16'h1234);
        for (int i = 0; i < 65535; i++) run_slot(0, 1, 0, 0);
        chk("R9 zero length still running", dma_run, 1);
        run_slot(0, 1, 0, 0);
        chk("R9 zero length ends at 65536", dma_run, 0);

        // constrained random mix
        for (int r = 0; r < 400; r++) begin
            if (!m_run) begin
                logic [23:0] s;
                logic [3:0]  cd;
                int pick = $urandom_range(0, 3);
                cd = (pick == 0) ? 4'h1 : (pick == 1) ? 4'h3 : (pick == 2) ? 4'h5 : 4'h7;
                s = $urandom;
                do_cfg(s, 16'($urandom_range(1, 6)), 16'($urandom), 8'($urandom_range(0, 4)),
                       {($urandom_range(0, 7) != 0), 1'($urandom), cd});
                if (mode_of(s) == 1) do_host(16'($urandom));
            end
            for (int k = 0; k < 30 && m_run; k++) begin
                int idx;
                int sel = $urandom_range(0, 9);
                case (sel)
                    0: idx = 37;  1: idx = 38;  2: idx = 24;  3: idx = 25;
                    4: idx = 0;   5: idx = 210; 6: idx = 255;
                    default: idx = $urandom_range(0, 255);
                endcase
                if ($urandom_range(0, 7) == 0 && (mode_of(m_src) != 1 || m_len > 1))
                    do_host(16'($urandom));
                run_slot(idx, 1'($urandom), 1'($urandom), $urandom_range(0, 4) == 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule